// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler

This block turns a core clock into the timing grid of an SPI serial clock. It reads an eight-bit prescale field and a one-bit encoding select. From them it decodes a divisor, then emits a one-cycle tick at every half period of the serial clock. A shifter downstream toggles its clock pin or samples data on each tick, and uses the phase output to tell the leading half from the trailing half.

Two encodings of the field are supported. The compact encoding gives only even divisors between 4 and 30. The scaled encoding multiplies a four-bit mantissa by a power of two. Its three-bit exponent is spread over two separate places in the field, so a decoder that reads the field as one contiguous number gets the wrong divisor.

The decoded configuration is captured only while the divider is stopped. A running divider therefore never sees a half-written setting. Each time the run input goes high, counting starts again from the beginning of a leading half period.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: With `ext_mode_i` = 0, the low five field bits form a code; a code c from 0x12 to 0x1F gives divisor 2·(c − 0x10), so 0x12 → 4, 0x15 → 10, 0x16 → 12 and 0x1F → 30; field bits [7:5] have no effect in this encoding.
- R2: With `ext_mode_i` = 0, any code below 0x12 (for example 0x00, 0x07, 0x11) gives divisor 4.
- R3: With `ext_mode_i` = 1, the divisor is the mantissa field[3:0] shifted left by an exponent whose bit 0 is field[4] and whose bits 2:1 are field[7:6]; field bit 5 has no effect. Examples: 0x03 → 3, 0x2F → 15, 0x15 → 10, 0x47 → 28, 0xC7 → 448, 0xDF → 1920, 0x11 → 2.
- R4: With `ext_mode_i` = 1, a product below 2 (mantissa 0 with any exponent, or mantissa 1 with exponent 0) gives divisor 2.
- R5: `ext_mode_i` selects between the encodings: the same field 0x0C gives divisor 4 with select 0 and divisor 12 with select 1.
- R6: For an even divisor D, while running, `tick_o` pulses once every D/2 cycles and `half_o` toggles on every tick.
- R7: For an odd divisor D, the first half period after a start lasts (D+1)/2 cycles and the next lasts (D−1)/2 cycles, alternating, so each full period is D cycles.
- R8: While `run_i` is low, `tick_o` and `half_o` stay 0. After `run_i` rises, the first tick comes ceil(D/2) cycles after the first clock edge that samples `run_i` high.
- R9: Changes to the field or the select while `run_i` is high do not affect `div_o` or the tick timing. The divisor is loaded on every clock edge that samples `run_i` low, so it shows on `div_o` one cycle after the inputs are applied.
- R10: Reset holds `tick_o` = 0, `half_o` = 0 and `div_o` = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Divider enable; configuration is loaded while low |
| ext_mode_i | input | 1 | Encoding select: 0 compact even-only, 1 mantissa/exponent |
| psc_field_i | input | 8 | Raw prescale field |
| tick_o | output | 1 | One-cycle pulse at each serial-clock half period |
| half_o | output | 1 | Current half: 0 leading, 1 trailing; toggles with each tick |
| div_o | output | 11 | Divisor currently in effect |

## Verification
The bound checker checks these properties on every cycle:
- the divisor never falls below 2;
- the divisor holds steady while running;
- a stopped divider never ticks;
- the phase changes exactly when a tick occurs;
- a divisor of 2 ticks on every running cycle;
- the gap between ticks never exceeds the divisor.

Some behaviour needs the bench's scenarios and its cycle reference model. These are the decoded values of each encoding, including the scattered exponent bits, the ignored field bits and both clamps. They also include the alternating half lengths for odd divisors and the latency to the first tick after a start.

// File: rtl/spi_psc_pkg.sv
package spi_psc_pkg;

   // Encoding selected by the mode input
   typedef enum logic {
      PSC_ENC_COMPACT = 1'b0,
      PSC_ENC_SCALED  = 1'b1
   } psc_enc_e;

   // Half of the serial-clock period currently being timed
   typedef enum logic {
      PSC_HALF_LEAD  = 1'b0,
      PSC_HALF_TRAIL = 1'b1
   } psc_half_e;

endpackage

// File: rtl/spi_psc_compact_dec.sv
// Compact encoding: code = base + divisor/2, codes below a floor map to a fixed divisor.
module spi_psc_compact_dec #(
   parameter int CODE_W    = 5,
   parameter int DIV_W     = 11,
   parameter int BASE      = 16,
   parameter int MIN_CODE  = 18,
   parameter int FLOOR_DIV = 4
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DIV_W-1:0]  div_o
);

   logic [DIV_W-1:0] half_div;
   logic             below_floor;

   assign below_floor = (code_i < CODE_W'(MIN_CODE));
   assign half_div    = DIV_W'(code_i) - DIV_W'(BASE);

   always_comb begin
      if (below_floor) begin
         div_o = DIV_W'(FLOOR_DIV);
      end else begin
         div_o = half_div << 1;
      end
   end

endmodule

// File: rtl/spi_psc_scaled_dec.sv
// Scaled encoding: mantissa shifted left by a power-of-two exponent, with a lower clamp.
module spi_psc_scaled_dec #(
   parameter int MANT_W  = 4,
   parameter int EXP_W   = 3,
   parameter int DIV_W   = 11,
   parameter int MIN_DIV = 2
) (
   input  logic [MANT_W-1:0] mant_i,
   input  logic [EXP_W-1:0]  exp_i,
   output logic [DIV_W-1:0]  div_o
);

   logic [DIV_W-1:0] stage [EXP_W+1];

   assign stage[0] = DIV_W'(mant_i);

   // One barrel-shifter stage per exponent bit
   for (genvar s = 0; s < EXP_W; s++) begin : g_shift
      assign stage[s+1] = exp_i[s] ? (stage[s] << (1 << s)) : stage[s];
   end

   always_comb begin
      if (stage[EXP_W] < DIV_W'(MIN_DIV)) begin
         div_o = DIV_W'(MIN_DIV);
      end else begin
         div_o = stage[EXP_W];
      end
   end

endmodule

// File: rtl/spi_psc_half_split.sv
// Splits a divisor into leading (rounded up) and trailing (rounded down) half lengths,
// expressed as terminal counter values.
module spi_psc_half_split #(
   parameter int DIV_W = 11,
   parameter int CNT_W = 10
) (
   input  logic [DIV_W-1:0] div_i,
   output logic [CNT_W-1:0] last_lead_o,
   output logic [CNT_W-1:0] last_trail_o
);

   logic [DIV_W:0]   div_up;
   logic [CNT_W-1:0] lead_len;
   logic [CNT_W-1:0] trail_len;

   assign div_up       = {1'b0, div_i} + {{DIV_W{1'b0}}, 1'b1};
   assign lead_len     = CNT_W'(div_up >> 1);
   assign trail_len    = CNT_W'(div_i >> 1);
   assign last_lead_o  = lead_len - CNT_W'(1);
   assign last_trail_o = trail_len - CNT_W'(1);

endmodule

// File: rtl/spi_psc_tick_gen.sv
// Half-period counter producing the tick and the half indicator.
module spi_psc_tick_gen
   import spi_psc_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CNT_W-1:0] last_lead_i,
   input  logic [CNT_W-1:0] last_trail_i,
   output logic             tick_o,
   output logic             half_o
);

   logic [CNT_W-1:0] cnt_q;
   psc_half_e        half_q;
   logic             tick_q;
   logic [CNT_W-1:0] last_sel;

   assign last_sel = (half_q == PSC_HALF_TRAIL) ? last_trail_i : last_lead_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         half_q <= PSC_HALF_LEAD;
         tick_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         half_q <= PSC_HALF_LEAD;
         tick_q <= 1'b0;
      end else if (cnt_q == last_sel) begin
         cnt_q  <= '0;
         half_q <= (half_q == PSC_HALF_LEAD) ? PSC_HALF_TRAIL : PSC_HALF_LEAD;
         tick_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + CNT_W'(1);
         tick_q <= 1'b0;
      end
   end

   assign tick_o = tick_q;
   assign half_o = (half_q == PSC_HALF_TRAIL);

endmodule

// File: rtl/spi_sclk_prescaler.sv
// Top level: field decode, configuration capture while idle, half-period tick generation.
module spi_sclk_prescaler
   import spi_psc_pkg::*;
#(
   parameter int FIELD_W       = 8,
   parameter int MANT_W        = 4,
   parameter int EXP_W         = 3,
   parameter int EXP_LO_POS    = 4,
   parameter int EXP_HI_POS    = 6,
   parameter int CODE_W        = 5,
   parameter int CODE_BASE     = 16,
   parameter int CODE_MIN      = 18,
   parameter int CODE_FLOOR    = 4,
   parameter int SCALED_MIN    = 2,
   parameter int RESET_DIV     = 4,
   parameter bit HAS_COMPACT   = 1'b1,
   parameter bit HAS_SCALED    = 1'b1,
   localparam int DIV_W        = MANT_W + (1 << EXP_W) - 1,
   localparam int CNT_W        = DIV_W - 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               run_i,
   input  logic               ext_mode_i,
   input  logic [FIELD_W-1:0] psc_field_i,
   output logic               tick_o,
   output logic               half_o,
   output logic [DIV_W-1:0]   div_o
);

   // Elaboration-time parameter checks
   if (!(HAS_COMPACT || HAS_SCALED)) begin : g_err_variant
      $error("spi_sclk_prescaler: at least one encoding must be enabled");
   end
   if (EXP_W < 2) begin : g_err_exp_w
      $error("spi_sclk_prescaler: exponent needs at least two bits");
   end
   if (EXP_HI_POS + EXP_W - 1 > FIELD_W || EXP_LO_POS >= FIELD_W || MANT_W > FIELD_W) begin : g_err_layout
      $error("spi_sclk_prescaler: scaled field layout exceeds field width");
   end
   if (CODE_W > FIELD_W) begin : g_err_code_w
      $error("spi_sclk_prescaler: compact code wider than field");
   end
   if (SCALED_MIN < 2 || CODE_FLOOR < 2 || RESET_DIV < 2) begin : g_err_min
      $error("spi_sclk_prescaler: divisors below 2 cannot form two half periods");
   end
   if (2 * ((1 << CODE_W) - 1 - CODE_BASE) >= (1 << DIV_W)) begin : g_err_compact_range
      $error("spi_sclk_prescaler: compact divisor range exceeds divisor width");
   end

   logic [DIV_W-1:0] dec_div;
   logic [DIV_W-1:0] act_div_q;
   logic [CNT_W-1:0] last_lead;
   logic [CNT_W-1:0] last_trail;
   logic             unused_inputs;

   // Bits that some encodings leave out (e.g. the gap between exponent fields)
   assign unused_inputs = ^{psc_field_i, ext_mode_i};

   // Decoder variant selection
   if (HAS_COMPACT && HAS_SCALED) begin : g_both
      logic [DIV_W-1:0] compact_div;
      logic [DIV_W-1:0] scaled_div;
      logic [EXP_W-1:0] exp_bits;
      psc_enc_e         enc;

      assign exp_bits = {psc_field_i[EXP_HI_POS +: EXP_W-1], psc_field_i[EXP_LO_POS]};
      assign enc      = psc_enc_e'(ext_mode_i);

      spi_psc_compact_dec #(
         .CODE_W   (CODE_W),
         .DIV_W    (DIV_W),
         .BASE     (CODE_BASE),
         .MIN_CODE (CODE_MIN),
         .FLOOR_DIV(CODE_FLOOR)
      ) u_compact (
         .code_i(psc_field_i[CODE_W-1:0]),
         .div_o (compact_div)
      );

      spi_psc_scaled_dec #(
         .MANT_W (MANT_W),
         .EXP_W  (EXP_W),
         .DIV_W  (DIV_W),
         .MIN_DIV(SCALED_MIN)
      ) u_scaled (
         .mant_i(psc_field_i[MANT_W-1:0]),
         .exp_i (exp_bits),
         .div_o (scaled_div)
      );

      assign dec_div = (enc == PSC_ENC_SCALED) ? scaled_div : compact_div;
   end else if (HAS_SCALED) begin : g_scaled_only
      logic [EXP_W-1:0] exp_bits;
      assign exp_bits = {psc_field_i[EXP_HI_POS +: EXP_W-1], psc_field_i[EXP_LO_POS]};

      spi_psc_scaled_dec #(
         .MANT_W (MANT_W),
         .EXP_W  (EXP_W),
         .DIV_W  (DIV_W),
         .MIN_DIV(SCALED_MIN)
      ) u_scaled (
         .mant_i(psc_field_i[MANT_W-1:0]),
         .exp_i (exp_bits),
         .div_o (dec_div)
      );
   end else begin : g_compact_only
      spi_psc_compact_dec #(
         .CODE_W   (CODE_W),
         .DIV_W    (DIV_W),
         .BASE     (CODE_BASE),
         .MIN_CODE (CODE_MIN),
         .FLOOR_DIV(CODE_FLOOR)
      ) u_compact (
         .code_i(psc_field_i[CODE_W-1:0]),
         .div_o (dec_div)
      );
   end

   // Configuration capture: follows the field only while the divider is stopped
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_div_q <= DIV_W'(RESET_DIV);
      end else if (!run_i) begin
         act_div_q <= dec_div;
      end
   end

   spi_psc_half_split #(
      .DIV_W(DIV_W),
      .CNT_W(CNT_W)
   ) u_split (
      .div_i       (act_div_q),
      .last_lead_o (last_lead),
      .last_trail_o(last_trail)
   );

   spi_psc_tick_gen #(
      .CNT_W(CNT_W)
   ) u_tick (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_i),
      .last_lead_i (last_lead),
      .last_trail_i(last_trail),
      .tick_o      (tick_o),
      .half_o      (half_o)
   );

   assign div_o = act_div_q;

endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk #(
   parameter int DIV_W = 11
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             run_i,
   input logic             tick_o,
   input logic             half_o,
   input logic [DIV_W-1:0] div_o
);

   logic [DIV_W:0] gap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gap_q <= '0;
      end else if (!run_i || tick_o) begin
         gap_q <= '0;
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // R4
   div_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_o >= DIV_W'(2));

   // R9
   div_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(run_i) |-> $stable(div_o));

   // R8
   idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(run_i) |-> (!tick_o && !half_o));

   // R6
   phase_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |-> (half_o != $past(half_o)));

   // R6
   phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_o && $past(run_i)) |-> $stable(half_o));

   // R4
   fastest_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(run_i) && div_o == DIV_W'(2)) |-> tick_o);

   // R7
   gap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gap_q < {1'b0, div_o});

endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk #(
   .DIV_W(DIV_W)
) u_chk (
   .clk_i (clk_i),
   .rst_ni(rst_ni),
   .run_i (run_i),
   .tick_o(tick_o),
   .half_o(half_o),
   .div_o (div_o)
);

// File: tb/spi_sclk_prescaler_tb.sv
module spi_sclk_prescaler_tb;

   localparam int DW = 11;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          run;
   logic          mode;
   logic [7:0]    fld;
   logic          tick;
   logic          half;
   logic [DW-1:0] div;

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   string cur_req = "R10";

   // Behavioural reference state
   int m_cnt, m_half, m_tick, m_div;

   always #4 clk = ~clk;

   spi_sclk_prescaler u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .run_i      (run),
      .ext_mode_i (mode),
      .psc_field_i(fld),
      .tick_o     (tick),
      .half_o     (half),
      .div_o      (div)
   );

   function automatic int ref_div(bit m, int f);
      int c, s, e, d;
      if (!m) begin
         c = f % 32;
         d = (c < 18) ? 4 : 2 * (c - 16);
      end else begin
         s = f % 16;
         e = ((f / 64) % 4) * 2 + ((f / 16) % 2);
         d = s * (1 << e);
         if (d < 2) d = 2;
      end
      return d;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      int len;
      if (!rst_n) begin
         m_cnt = 0; m_half = 0; m_tick = 0; m_div = 4;
      end else if (!run) begin
         m_cnt = 0; m_half = 0; m_tick = 0; m_div = ref_div(mode, int'(fld));
      end else begin
         len = (m_half != 0) ? m_div / 2 : (m_div + 1) / 2;
         if (m_cnt + 1 >= len) begin
            m_cnt = 0; m_half = 1 - m_half; m_tick = 1;
         end else begin
            m_cnt = m_cnt + 1; m_tick = 0;
         end
      end
   end

   // Cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         checks++;
         if (tick !== (m_tick != 0) || half !== (m_half != 0) || div !== DW'(m_div)) begin
            errors++;
            $display("FAIL %s cycle compare: tick=%0b half=%0b div=%0d expected tick=%0d half=%0d div=%0d",
                     cur_req, tick, half, div, m_tick, m_half, m_div);
         end
      end
   end

   task automatic chk_val(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cfg(input bit m, input logic [7:0] f, input int exp, input string tag);
      run  = 1'b0;
      mode = m;
      fld  = f;
      @(negedge clk);
      chk_val(int'(div), exp, tag);
   endtask

   task automatic run_for(input int n);
      run = 1'b1;
      repeat (n) @(negedge clk);
      run = 1'b0;
      @(negedge clk);
   endtask

   task automatic first_tick(input int exp, input string tag);
      int n = 0;
      run = 1'b1;
      do begin
         @(negedge clk);
         n++;
      end while (tick !== 1'b1 && n < 4000);
      chk_val(n, exp, tag);
      repeat (6) @(negedge clk);
      run = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=expired expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; run = 1'b0; mode = 1'b0; fld = 8'h00;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk_val(int'(tick), 0, "R10 tick");
      chk_val(int'(half), 0, "R10 half");
      chk_val(int'(div), 4, "R10 div");
      rst_n = 1'b1;
      @(negedge clk);

      // R1 compact encoding, R6 even timing
      cur_req = "R1";
      cfg(1'b0, 8'h12, 4,  "R1 code 0x12");  cur_req = "R6"; run_for(20);
      cfg(1'b0, 8'h1F, 30, "R1 code 0x1F");  cur_req = "R6"; run_for(70);
      cfg(1'b0, 8'h15, 10, "R1 code 0x15");  cur_req = "R6"; run_for(30);
      cfg(1'b0, 8'hF6, 12, "R1 upper bits ignored");
      // R2 codes below the floor
      cur_req = "R2";
      cfg(1'b0, 8'hE7, 4, "R2 code 0x07");
      cfg(1'b0, 8'h11, 4, "R2 code 0x11");
      cfg(1'b0, 8'h00, 4, "R2 code 0x00"); run_for(12);

      // R3 scaled encoding, R7 odd timing
      cur_req = "R3";
      cfg(1'b1, 8'h03, 3,  "R3 0x03");  cur_req = "R7"; run_for(25);
      cfg(1'b1, 8'h2F, 15, "R3 bit5 ignored"); cur_req = "R7"; run_for(50);
      cur_req = "R3";
      cfg(1'b1, 8'h15, 10,   "R3 0x15");
      cfg(1'b1, 8'h47, 28,   "R3 0x47"); run_for(60);
      cfg(1'b1, 8'hC7, 448,  "R3 0xC7");
      cfg(1'b1, 8'h11, 2,    "R3 0x11");
      cfg(1'b1, 8'hDF, 1920, "R3 0xDF"); run_for(3900);

      // R4 clamp
      cur_req = "R4";
      cfg(1'b1, 8'h00, 2, "R4 0x00"); run_for(10);
      cfg(1'b1, 8'h01, 2, "R4 0x01");
      cfg(1'b1, 8'h10, 2, "R4 0x10");
      cfg(1'b1, 8'hD0, 2, "R4 0xD0");

      // R5 encoding select
      cur_req = "R5";
      cfg(1'b0, 8'h0C, 4,  "R5 select compact");
      cfg(1'b1, 8'h0C, 12, "R5 select scaled");

      // R8 first tick latency after start
      cur_req = "R8";
      cfg(1'b1, 8'h15, 10, "R8 setup D=10");
      first_tick(5, "R8 first tick D=10");
      cfg(1'b1, 8'h03, 3, "R8 setup D=3");
      first_tick(2, "R8 first tick D=3");
      cfg(1'b1, 8'hDF, 1920, "R8 setup D=1920");
      first_tick(960, "R8 first tick D=1920");

      // R9 changes while running are ignored
      cur_req = "R9";
      cfg(1'b1, 8'h03, 3, "R9 setup");
      run = 1'b1;
      repeat (5) @(negedge clk);
      mode = 1'b0;
      fld  = 8'hDF;
      repeat (20) @(negedge clk);
      chk_val(int'(div), 3, "R9 divisor frozen while running");
      run = 1'b0;
      @(negedge clk);
      chk_val(int'(div), 30, "R9 new setting after stop");
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule